// File: doc/BRIEF.md
# Serial Audio Codec Frame Link

This block connects a parallel filter datapath to an audio codec. The codec uses an MSB-first serial format that is not I2S. Everything runs from one system clock with an active-low reset. A free-running divider produces the codec master clock, the bit clock and the left/right frame clock. Each half of the frame clock period is one channel slot of 32 bit clocks. The frame clock is high for the left channel and low for the right channel.

On the receive side, the block shifts in the first 8 bits of each slot. These are the top 8 bits of the codec's 20-bit word. When the frame clock next changes, the block presents that byte on a per-channel parallel output with a one-cycle valid pulse. On the transmit side, the block captures a 16-bit word for the channel that is starting at each frame clock edge. It shifts that word out MSB first and then pads the rest of the slot with zeros. Bit positions are counted from each frame clock edge. All logic stays in the system clock domain, and the divided clocks are used only as port outputs.

Top module: `audio_frame_link`

## Requirements
- R1: With a system clock period T, mclk has period 4T, bclk has period 16T and lrck has period 1024T. lrck changes only on the system edge where bclk falls, so each lrck level holds exactly 32 bclk rising edges.
- R2: While rstN is low, every output is 0: mclk, bclk, lrck, sdOut, rxLeft, rxRight, rxValid, rxChan and txLoad.
- R3: sdIn is sampled at the system edge where bclk rises. The first 8 samples of a slot are assembled MSB first, with the first sample as bit 7. Samples from the lrck-high slot go to rxLeft and samples from the lrck-low slot go to rxRight.
- R4: Slot samples 9 through 32 have no effect on rxLeft or rxRight.
- R5: A received byte appears on its output one system cycle after the slot-ending lrck change. At the same time, rxValid is high for exactly one cycle, and rxChan gives the slot that ended (1 = left, 0 = right).
- R6: During the lrck-high slot, sdOut carries txLeft bits 15 down to 0 on the first 16 bit periods. During the lrck-low slot it carries txRight the same way.
- R7: sdOut is 0 for bit periods 17 through 32 of every slot.
- R8: txLoad is high for exactly the one system cycle after each lrck change, and the transmit word is sampled at the end of that cycle. Changes to txLeft or txRight later in the slot do not alter the bits being sent.
- R9: sdOut changes only one system cycle after a bclk falling edge, so it is stable for the whole time bclk is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sdIn | input | 1 | Serial data from the codec |
| txLeft | input | 16 | Left-channel transmit sample |
| txRight | input | 16 | Right-channel transmit sample |
| mclk | output | 1 | Codec master clock, system clock divided by 4 |
| bclk | output | 1 | Bit clock, system clock divided by 16 |
| lrck | output | 1 | Frame clock, high for the left slot |
| sdOut | output | 1 | Serial data to the codec |
| rxLeft | output | 8 | Latest left-channel received byte |
| rxRight | output | 8 | Latest right-channel received byte |
| rxValid | output | 1 | One-cycle pulse when a received byte is latched |
| rxChan | output | 1 | Channel of the latched byte, 1 = left |
| txLoad | output | 1 | High in the cycle whose end samples a transmit word |

## Verification
The assertions check the following on every cycle:
- the frame clock changes only together with a bit-clock fall;
- the master clock has period 4T;
- the outputs are clear when reset is released;
- the valid pulse is one cycle long and follows a frame edge by one cycle with the right channel flag;
- txLoad marks exactly the cycles after frame edges;
- serial output changes only one cycle after a bit-clock fall.

Other behaviour needs the bench's scenarios:
- the bit, slot and frame periods;
- which slot positions reach the received bytes, and that the trailing bits in each slot are ignored;
- the exact bit pattern sent for each channel, including the zero padding;
- that a transmit input changed mid-slot has no effect.

// File: rtl/afl_pkg.sv
package afl_pkg;

  // Strobes from the control path to the datapath, valid for one system cycle
  typedef struct packed {
    logic frameEdge;  // cycle right after an lrck change
    logic newLeft;    // slot now starting is the left one
    logic endedLeft;  // slot that just finished was the left one
    logic txAdvance;  // put the next word bit on sdOut
    logic txPad;      // put a pad zero on sdOut
    logic rxCapture;  // shift sdIn into the receive register
  } afl_strobe_t;

endpackage

// File: rtl/afl_clkgen.sv
module afl_clkgen #(
  parameter int CNT_W    = 10,
  parameter int MCLK_TAP = 1,
  parameter int BCLK_TAP = 3,
  parameter int LRCK_TAP = 9
) (
  input  logic clk,
  input  logic rstN,
  output logic mclk,
  output logic bclk,
  output logic lrck,
  output logic sampleEn,  // next edge raises bclk
  output logic driveEn    // bclk fell on the previous edge
);

  localparam int PH_W = BCLK_TAP + 1;
  localparam logic [PH_W-1:0] PH_LAST_LOW = {1'b0, {BCLK_TAP{1'b1}}};

  logic [CNT_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  assign mclk = divCnt[MCLK_TAP];
  assign bclk = divCnt[BCLK_TAP];
  assign lrck = divCnt[LRCK_TAP];

  assign sampleEn = rstN && (divCnt[BCLK_TAP:0] == PH_LAST_LOW);
  assign driveEn  = rstN && (divCnt[BCLK_TAP:0] == '0);

endmodule

// File: rtl/afl_ctrl.sv
module afl_ctrl
  import afl_pkg::*;
#(
  parameter int RX_BITS = 8,
  parameter int TX_BITS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lrck,
  input  logic        sampleEn,
  input  logic        driveEn,
  output afl_strobe_t strobe
);

  localparam int RXI_W = $clog2(RX_BITS + 1);
  localparam int TXI_W = $clog2(TX_BITS + 1);
  localparam logic [RXI_W-1:0] RX_END = RXI_W'(RX_BITS);
  localparam logic [TXI_W-1:0] TX_END = TXI_W'(TX_BITS);

  logic             lrckD;
  logic [RXI_W-1:0] rxIdx;
  logic [TXI_W-1:0] txIdx;
  logic             edgeNow;

  assign edgeNow = lrck ^ lrckD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lrckD <= 1'b0;
    else       lrckD <= lrck;
  end

  // Slot positions restart at every frame edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxIdx <= '0;
      txIdx <= '0;
    end else if (edgeNow) begin
      rxIdx <= '0;
      txIdx <= TXI_W'(1);
    end else begin
      if (sampleEn && (rxIdx < RX_END)) rxIdx <= rxIdx + 1'b1;
      if (driveEn && (txIdx < TX_END))  txIdx <= txIdx + 1'b1;
    end
  end

  always_comb begin
    strobe.frameEdge = edgeNow;
    strobe.newLeft   = lrck;
    strobe.endedLeft = lrckD;
    strobe.txAdvance = driveEn && !edgeNow && (txIdx < TX_END);
    strobe.txPad     = driveEn && !edgeNow && (txIdx >= TX_END);
    strobe.rxCapture = sampleEn && !edgeNow && (rxIdx < RX_END);
  end

endmodule

// File: rtl/afl_datapath.sv
module afl_datapath
  import afl_pkg::*;
#(
  parameter int RX_BITS = 8,
  parameter int TX_BITS = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  afl_strobe_t        strobe,
  input  logic               sdIn,
  input  logic [TX_BITS-1:0] txLeft,
  input  logic [TX_BITS-1:0] txRight,
  output logic               sdOut,
  output logic [RX_BITS-1:0] rxLeft,
  output logic [RX_BITS-1:0] rxRight,
  output logic               rxValid,
  output logic               rxChan
);

  localparam int NUM_CH = 2;  // index 1 = left, 0 = right

  logic [RX_BITS-1:0] rxShift;
  logic [RX_BITS-1:0] rxHold [NUM_CH];
  logic [TX_BITS-1:0] txShift;
  logic [TX_BITS-1:0] txWord;

  // Receive shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rxShift <= '0;
    else if (strobe.frameEdge) rxShift <= '0;
    else if (strobe.rxCapture) rxShift <= {rxShift[RX_BITS-2:0], sdIn};
  end

  // Per-channel output holding registers
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_rxHold
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rxHold[ch] <= '0;
      else if (strobe.frameEdge && (strobe.endedLeft == (ch == 1)))
        rxHold[ch] <= rxShift;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxChan  <= 1'b0;
    end else begin
      rxValid <= strobe.frameEdge;
      if (strobe.frameEdge) rxChan <= strobe.endedLeft;
    end
  end

  assign rxLeft  = rxHold[1];
  assign rxRight = rxHold[0];

  // Transmit: word captured at slot start, MSB leaves first
  assign txWord = strobe.newLeft ? txLeft : txRight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      sdOut   <= 1'b0;
    end else if (strobe.frameEdge) begin
      sdOut   <= txWord[TX_BITS-1];
      txShift <= {txWord[TX_BITS-2:0], 1'b0};
    end else if (strobe.txAdvance) begin
      sdOut   <= txShift[TX_BITS-1];
      txShift <= {txShift[TX_BITS-2:0], 1'b0};
    end else if (strobe.txPad) begin
      sdOut   <= 1'b0;
    end
  end

endmodule

// File: rtl/audio_frame_link.sv
module audio_frame_link
  import afl_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int MCLK_TAP = 1,
  parameter int BCLK_TAP = 3,
  parameter int LRCK_TAP = 9,
  parameter int RX_BITS  = 8,
  parameter int TX_BITS  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sdIn,
  input  logic [TX_BITS-1:0] txLeft,
  input  logic [TX_BITS-1:0] txRight,
  output logic               mclk,
  output logic               bclk,
  output logic               lrck,
  output logic               sdOut,
  output logic [RX_BITS-1:0] rxLeft,
  output logic [RX_BITS-1:0] rxRight,
  output logic               rxValid,
  output logic               rxChan,
  output logic               txLoad
);

  afl_strobe_t strobe;
  logic        sampleEn;
  logic        driveEn;

  afl_clkgen #(
    .CNT_W(CNT_W), .MCLK_TAP(MCLK_TAP), .BCLK_TAP(BCLK_TAP), .LRCK_TAP(LRCK_TAP)
  ) i_clkgen (
    .clk(clk), .rstN(rstN), .mclk(mclk), .bclk(bclk), .lrck(lrck),
    .sampleEn(sampleEn), .driveEn(driveEn)
  );

  afl_ctrl #(.RX_BITS(RX_BITS), .TX_BITS(TX_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .lrck(lrck), .sampleEn(sampleEn),
    .driveEn(driveEn), .strobe(strobe)
  );

  afl_datapath #(.RX_BITS(RX_BITS), .TX_BITS(TX_BITS)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdIn(sdIn),
    .txLeft(txLeft), .txRight(txRight), .sdOut(sdOut),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid), .rxChan(rxChan)
  );

  assign txLoad = strobe.frameEdge;

endmodule

// File: rtl/afl_checker.sv
module afl_checker #(
  parameter int RX_BITS = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               mclk,
  input logic               bclk,
  input logic               lrck,
  input logic               sdOut,
  input logic [RX_BITS-1:0] rxLeft,
  input logic [RX_BITS-1:0] rxRight,
  input logic               rxValid,
  input logic               rxChan,
  input logic               txLoad
);

  // R1: frame clock moves only with a bit-clock fall
  a_r1_lrck_on_bclk_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lrck) |-> $fell(bclk));

  // R1: master clock holds each level for two system cycles
  a_r1_mclk_half_period: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mclk) |=> $stable(mclk));

  // R2: registers come out of reset clear
  a_r2_reset_clear: assert property (@(posedge clk)
    $rose(rstN) |-> (sdOut == 1'b0 && rxValid == 1'b0 && rxLeft == '0 &&
                     rxRight == '0 && bclk == 1'b0 && lrck == 1'b0));

  // R5: valid is a single-cycle pulse
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R5: valid follows a frame edge by one cycle and names the ended slot
  a_r5_valid_after_edge: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ($past(lrck, 2) != $past(lrck) && rxChan == $past(lrck, 2)));

  // R8: txLoad flags exactly the cycle after an lrck change
  a_r8_load_marks_edge: assert property (@(posedge clk) disable iff (!rstN)
    txLoad == (lrck != $past(lrck)));

  // R9: serial output moves one cycle after a bit-clock fall
  a_r9_sdout_timing: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdOut) |-> (!bclk && !$past(bclk) && $past(bclk, 2)));

endmodule

bind audio_frame_link afl_checker #(.RX_BITS(RX_BITS)) i_afl_checker (
  .clk(clk), .rstN(rstN), .mclk(mclk), .bclk(bclk), .lrck(lrck),
  .sdOut(sdOut), .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid),
  .rxChan(rxChan), .txLoad(txLoad)
);

// File: tb/test_audio_frame_link.sv
`timescale 1ns/1ps
module test_audio_frame_link;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sdIn = 1'b0;
  logic [15:0] txLeft = '0;
  logic [15:0] txRight = '0;
  logic        mclk, bclk, lrck, sdOut, rxValid, rxChan, txLoad;
  logic [7:0]  rxLeft, rxRight;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  audio_frame_link i_audio_frame_link (
    .clk(clk), .rstN(rstN), .sdIn(sdIn), .txLeft(txLeft), .txRight(txRight),
    .mclk(mclk), .bclk(bclk), .lrck(lrck), .sdOut(sdOut),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid), .rxChan(rxChan),
    .txLoad(txLoad)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // R2: all outputs low while reset is held
  task automatic test_reset(input string tag);
    logic [31:0] outs;
    outs = {mclk, bclk, lrck, sdOut, rxLeft, rxRight, rxValid, rxChan, txLoad};
    check(outs == '0, "R2", tag, outs, 0);
  endtask

  // R1: clock periods measured in system cycles
  task automatic test_clocks();
    int n;
    @(negedge clk); while (mclk) @(negedge clk);
    while (!mclk) @(negedge clk);
    n = 0; do begin @(negedge clk); n++; end while (!(mclk && n > 1 && n % 4 == 0) && n < 100);
    check(n == 4, "R1", "mclk period", n, 4);
    while (bclk) @(negedge clk);
    while (!bclk) @(negedge clk);
    n = 0; do begin @(negedge clk); n++; end while (!bclk || n < 9);
    check(n == 16, "R1", "bclk period", n, 16);
    while (lrck) @(negedge clk);
    while (!lrck) @(negedge clk);
    n = 0; do begin @(negedge clk); n++; end while (!lrck || n < 600);
    check(n == 1024, "R1", "lrck period", n, 1024);
  endtask

  function automatic logic codec_bit(input logic [19:0] w, input logic junk, input int idx);
    return (idx < 20) ? w[19 - idx] : junk;
  endfunction

  // One full left+right frame: codec drives sdIn, bench captures sdOut
  task automatic test_frame(input string tag, input logic [19:0] wl, input logic [19:0] wr,
                            input logic junk, input logic [15:0] tl, input logic [15:0] tr,
                            input bit midChange, input logic [15:0] tlAlt);
    logic pl, pb, ps;
    logic chan;
    int idx, loads, nL, nR, glitch, risesL, risesR;
    logic [31:0] capL, capR;
    logic [7:0] gotL, gotR;
    txLeft = tl; txRight = tr;
    @(negedge clk); pl = lrck;
    forever begin
      @(negedge clk);
      if (lrck && !pl) break;
      pl = lrck;
    end
    chan = 1'b1; idx = 0; sdIn = codec_bit(wl, junk, 0);
    loads = txLoad ? 1 : 0;
    nL = 0; nR = 0; glitch = 0; risesL = 0; risesR = 0;
    capL = '0; capR = '0; gotL = '0; gotR = '0;
    pl = lrck; pb = bclk; ps = sdOut;
    forever begin
      @(negedge clk);
      if (lrck != pl && lrck) break;
      loads += txLoad ? 1 : 0;
      if (rxValid) begin
        if (rxChan) begin nL++; gotL = rxLeft; end
        else        begin nR++; gotR = rxRight; end
      end
      if (lrck != pl) begin
        chan = 1'b0; idx = 0; sdIn = codec_bit(wr, junk, 0);
      end else if (pb && !bclk) begin
        idx++;
        sdIn = codec_bit(chan ? wl : wr, junk, idx);
      end
      if (!pb && bclk && idx < 32) begin
        if (chan) begin capL[31 - idx] = sdOut; risesL++; end
        else      begin capR[31 - idx] = sdOut; risesR++; end
      end
      if (pb && bclk && sdOut != ps) glitch++;
      if (midChange && chan && idx == 5) txLeft = tlAlt;
      pl = lrck; pb = bclk; ps = sdOut;
    end
    repeat (2) begin
      @(negedge clk);
      if (rxValid) begin
        if (rxChan) begin nL++; gotL = rxLeft; end
        else        begin nR++; gotR = rxRight; end
      end
    end
    check(risesL == 32 && risesR == 32, "R1", {tag, " bclk rises per slot"},
          {risesL, risesR}, {32'd32, 32'd32});
    check(gotL == wl[19:12], "R3", {tag, " left byte at pulse"}, gotL, wl[19:12]);
    check(gotR == wr[19:12], "R3", {tag, " right byte at pulse"}, gotR, wr[19:12]);
    check(rxLeft == wl[19:12] && rxRight == wr[19:12], "R4",
          {tag, " bytes untouched by trailing bits"}, {rxLeft, rxRight},
          {wl[19:12], wr[19:12]});
    check(nL == 1 && nR == 2, "R5", {tag, " valid pulses L/R"}, {nL, nR}, {32'd1, 32'd2});
    check(capL[31:16] == tl && capR[31:16] == tr, "R6", {tag, " sent words"},
          {capL[31:16], capR[31:16]}, {tl, tr});
    check(capL[15:0] == 0 && capR[15:0] == 0, "R7", {tag, " pad zeros"},
          {capL[15:0], capR[15:0]}, 0);
    check(loads == 2, "R8", {tag, " load pulses"}, loads, 2);
    check(glitch == 0, "R9", {tag, " sdOut stable while bclk high"}, glitch, 0);
  endtask

  // R2: reset asserted mid-operation clears everything at once
  task automatic test_mid_reset();
    repeat (700) @(negedge clk);
    rstN = 1'b0;
    #1;
    test_reset("mid-run reset");
    repeat (5) @(negedge clk);
    test_reset("mid-run reset held");
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset("held reset");
    rstN = 1'b1;
    test_clocks();
    test_frame("basic", 20'hA5123, 20'h3C7F0, 1'b0, 16'hBEEF, 16'h1234, 0, 16'h0);
    test_frame("junk ones", 20'h01FFF, 20'hFE000, 1'b1, 16'h8001, 16'h7FFE, 0, 16'h0);
    test_frame("mid change", 20'hFFFFF, 20'h00000, 1'b1, 16'hC3A5, 16'hFFFF, 1, 16'h0F0F);
    test_mid_reset();
    test_frame("after reset", 20'h80000, 20'h7FFFF, 1'b0, 16'h0001, 16'h8000, 0, 16'h0);
    finish_run();
  end

endmodule